// File: doc/BRIEF.md
# Stream Beat Expander (Upsampler)

This block sits on a valid/ready stream and turns every accepted input sample into a burst of output beats. The length of each burst is set at run time by an unsigned count of extra beats, so one input becomes `extraCount + 1` output beats. Every output beat carries a beat index that starts at zero for each new sample, plus a flag that marks the closing beat of the burst. The data of each beat is formed from the held sample, the index and that flag.

Two data mappings are available. In zero-fill mode, every beat before the closing one carries zero and the closing beat carries the sample. Driving the count with `rate - 1` therefore gives an integer upsampler by `rate`, ready for an interpolation filter further down the path. In hold mode, every beat of the burst repeats the sample. The index and the closing flag are exported alongside the data, so that downstream logic can use them.

The sample, the count and the mode are captured when the input is accepted, so they may change freely while a burst is in flight. As soon as the closing beat leaves, a new sample may be taken in the same cycle, which keeps the stream running with no bubble between bursts.

Top module: `beat_expander`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `outValid` is 0, `outIndex` is 0 and `inReady` is 1.
- R2: Each input accepted (`inValid` and `inReady` high at a rising edge) yields exactly `extraCount + 1` output beats. `extraCount` is sampled at that acceptance, and later changes do not affect the burst.
- R3: Within a burst, `outIndex` takes the values 0, 1, … , N in order (N being the captured count). It advances only on a cycle where `outValid` and `outReady` are both high.
- R4: `outLast` is 1 on beat N of the burst and 0 on every other beat.
- R5: With `modeHold` = 0 captured, the beats with index below N carry all-zero `outData` and beat N carries the accepted sample.
- R6: With `modeHold` = 1 captured, every beat of the burst carries the accepted sample. `modeHold` is sampled at acceptance, and later changes do not affect the burst.
- R7: A captured count of 0 gives a single beat with index 0, `outLast` = 1 and the sample as data, in either mode.
- R8: While a burst is in flight, `inReady` is 0 on every cycle except one where the closing beat is being accepted.
- R9: An input accepted on the same cycle as a closing beat starts its own burst on the next cycle, with `outValid` high and no idle cycle in between.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outIndex` and `outLast` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeHold | input | 1 | Mapping select, sampled at acceptance: 0 = zero-fill, 1 = hold |
| extraCount | input | CNT_W | Number of extra beats per sample, sampled at acceptance |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block can accept a sample |
| inData | input | DATA_W | Input sample |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the beat |
| outData | output | DATA_W | Output beat data |
| outIndex | output | CNT_W | Beat index within the burst |
| outLast | output | 1 | Closing beat of the burst |

## Verification
The closing beat of one burst can leave on the same cycle that the next sample is taken in. The bench provokes this by holding the next sample valid while the current burst drains, with `outReady` held high, random, or mostly low. On each such cycle it requires `outValid` to be high on the following cycle, and it checks that the new burst's beats match a scoreboard that was filled at acceptance. It also changes `modeHold` and `extraCount` right after each acceptance, which shows that the captured values and not the live ones shape the burst.

// File: rtl/beatx_pkg.sv
package beatx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture sample, count and mode this cycle
    logic last;   // current beat is the closing beat of the burst
  } beatx_strobe_t;
endpackage

// File: rtl/beatx_datapath.sv
module beatx_datapath
  import beatx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  beatx_strobe_t     strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  extraCount,
  input  logic              modeHold,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  heldCount
);
  logic [DATA_W-1:0] heldData;
  logic              heldMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldData  <= '0;
      heldCount <= '0;
      heldMode  <= 1'b0;
    end else if (strobe.load) begin
      heldData  <= inData;
      heldCount <= extraCount;
      heldMode  <= modeHold;
    end
  end

  // Beat mapping: hold repeats the sample, zero-fill emits it only on the closing beat
  always_comb begin
    if (heldMode || strobe.last) outData = heldData;
    else                         outData = '0;
  end

  // R6: in hold mode the output always equals the captured sample, one cycle after capture
  assert_hold_repeat_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && modeHold) |=> (outData == $past(inData)));
endmodule

// File: rtl/beatx_ctrl.sv
module beatx_ctrl
  import beatx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [CNT_W-1:0] heldCount,
  output logic             inReady,
  output logic             outValid,
  output logic [CNT_W-1:0] outIndex,
  output logic             outLast,
  output beatx_strobe_t    strobe
);
  logic             busy;
  logic [CNT_W-1:0] beatIdx;
  logic             isFinal;
  logic             fire;
  logic             accept;

  always_comb begin
    isFinal      = busy && (beatIdx == heldCount);
    fire         = busy && outReady;
    inReady      = !busy || (outReady && isFinal);
    accept       = inValid && inReady;
    strobe.load  = accept;
    strobe.last  = isFinal;
    outValid     = busy;
    outIndex     = beatIdx;
    outLast      = isFinal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      beatIdx <= '0;
    end else begin
      if (accept)                busy <= 1'b1;
      else if (fire && isFinal)  busy <= 1'b0;
      if (fire) begin
        if (isFinal) beatIdx <= '0;
        else         beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outIndex == '0 && inReady));

  assert_index_bound_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outIndex <= heldCount));

  assert_index_step_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !outLast) |=> (outValid && outIndex == $past(outIndex) + 1'b1));

  assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outIndex));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !(outReady && outLast)) |-> !inReady);

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast && inValid) |=> (outValid && outIndex == '0));
endmodule

// File: rtl/beat_expander.sv
module beat_expander
  import beatx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeHold,
  input  logic [CNT_W-1:0]  extraCount,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  outIndex,
  output logic              outLast
);
  beatx_strobe_t    strobe;
  logic [CNT_W-1:0] heldCount;

  beatx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .outReady  (outReady),
    .heldCount (heldCount),
    .inReady   (inReady),
    .outValid  (outValid),
    .outIndex  (outIndex),
    .outLast   (outLast),
    .strobe    (strobe)
  );

  beatx_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inData     (inData),
    .extraCount (extraCount),
    .modeHold   (modeHold),
    .outData    (outData),
    .heldCount  (heldCount)
  );

  assert_stall_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  assert_single_beat_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && extraCount == '0) |=> (outValid && outLast && outIndex == '0));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !modeHold && extraCount != '0) |=> (outData == '0));
endmodule

// File: tb/beat_expander_tb.sv
module beat_expander_tb;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          modeHold = 1'b0;
  logic [CW-1:0] extraCount = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [DW-1:0] outData;
  logic [CW-1:0] outIndex;
  logic          outLast;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [CW-1:0] i;
    logic          l;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   readyMode = 0;
  bit   monOn = 0;
  bit   done = 0;

  always #(PERIOD/2) clk = ~clk;

  beat_expander #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .modeHold(modeHold), .extraCount(extraCount),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outIndex(outIndex), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Downstream ready pattern
  initial begin
    forever begin
      @(negedge clk);
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = ($urandom % 2) == 0;
        default: outReady = ($urandom % 4) == 0;
      endcase
    end
  end

  // Driver: called at a negedge; holds the sample until accepted, pushes expected beats (R2, R5, R6, R7)
  task automatic sendItem(input logic [DW-1:0] d, input logic [CW-1:0] cnt, input bit hold);
    bit acc;
    inValid = 1'b1; inData = d; extraCount = cnt; modeHold = hold;
    do begin
      #(PERIOD/2 - 1);
      acc = inReady;
      if (acc) begin
        for (int k = 0; k <= int'(cnt); k++) begin
          exp_t e;
          e.d = (hold || k == int'(cnt)) ? d : '0;
          e.i = CW'(k);
          e.l = (k == int'(cnt));
          q.push_back(e);
        end
      end
      @(negedge clk);
    end while (!acc);
    // change the live controls right away; the burst must use the captured ones (R2, R6)
    inValid = 1'b0; inData = ~d; extraCount = ~cnt; modeHold = ~hold;
  endtask

  // Monitor: samples one time unit before each rising edge
  initial begin
    bit   expectNext = 0;
    bit   prevStall = 0;
    exp_t prevBeat = '0;
    forever begin
      @(negedge clk);
      #(PERIOD/2 - 1);
      if (monOn) begin
        if (expectNext)
          check(outValid === 1'b1, "R9 burst follows back-to-back accept", 32'(outValid), 32'd1);
        expectNext = 0;
        if (prevStall) begin
          check(outValid === 1'b1 && outData === prevBeat.d && outIndex === prevBeat.i && outLast === prevBeat.l,
                "R10 stall stability", {outData, outIndex, 3'b0, outLast}, {prevBeat.d, prevBeat.i, 3'b0, prevBeat.l});
        end
        if (outValid && !(outReady && outLast))
          check(inReady === 1'b0, "R8 inReady low mid-burst", 32'(inReady), 32'd0);
        if (outValid && outReady) begin
          if (q.size() == 0) begin
            check(1'b0, "R2 unexpected extra beat", {outData, outIndex}, 32'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(outData === e.d, e.l ? "R5/R6/R7 closing beat data" : "R5/R6 inner beat data", 32'(outData), 32'(e.d));
            check(outIndex === e.i, "R3 beat index", 32'(outIndex), 32'(e.i));
            check(outLast === e.l, "R4 closing flag", 32'(outLast), 32'(e.l));
          end
          if (outLast && inValid && inReady) expectNext = 1;
        end
        prevStall = outValid && !outReady;
        prevBeat.d = outData; prevBeat.i = outIndex; prevBeat.l = outLast;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check(outValid === 1'b0, "R1 outValid in reset", 32'(outValid), 32'd0);
    check(inReady === 1'b1, "R1 inReady in reset", 32'(inReady), 32'd1);
    @(negedge clk); rst = 1'b0;
    #(PERIOD/2 - 1);
    check(outValid === 1'b0 && outIndex === '0, "R1 idle after reset", {outValid, outIndex}, 32'd0);
    check(inReady === 1'b1, "R1 inReady after reset", 32'(inReady), 32'd1);
    monOn = 1;
    @(negedge clk);

    // Directed: zero-fill by 4, hold by 3, count 0 in both modes, max count
    readyMode = 0;
    sendItem(16'hA5A5, 4'd3, 1'b0);
    sendItem(16'h1234, 4'd2, 1'b1);
    sendItem(16'hBEEF, 4'd0, 1'b0);   // R7
    sendItem(16'hCAFE, 4'd0, 1'b1);   // R7
    sendItem(16'h0F0F, 4'd15, 1'b0);
    sendItem(16'h7777, 4'd1, 1'b1);
    repeat (3) @(negedge clk);

    // Random bursts under three ready patterns, mostly back-to-back
    for (int p = 0; p < 3; p++) begin
      readyMode = p;
      for (int n = 0; n < 25; n++) begin
        sendItem(DW'($urandom), CW'($urandom % 6), bit'($urandom % 2));
        if (($urandom % 4) == 0) @(negedge clk);
      end
    end

    readyMode = 0;
    for (int w = 0; w < 200 && (q.size() != 0 || outValid); w++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R2 all expected beats delivered", 32'(q.size()), 32'd0);
    check(outValid === 1'b0, "R2 no beat after bursts end", 32'(outValid), 32'd0);
    done = 1;
    finishRun();
  end
endmodule